// File: doc/BRIEF.md
# Simultaneous-Multithreading Issue Slot Allocator

This block hands out the issue slots of one machine cycle to the hardware thread contexts that have ready work. Each thread offers a count of ready instructions and a stall flag. The allocator walks the threads in rotation order and gives each eligible thread a contiguous run of slots, up to a per-thread limit set by the current issue mode. For every slot it reports a valid bit and the owning thread number. For every thread it reports how many slots that thread received. It also reports how many slots went unused. The allocation is combinational from the inputs of the cycle, the registered mode and a registered rotation pointer.

The issue mode is a small state machine with five states: `MODE_FULL` (no per-thread limit), `MODE_CAP1`, `MODE_CAP2`, `MODE_CAP4` (limits of one, two and four instructions per thread) and `MODE_FINE` (a single thread takes the cycle, up to the full width). On every clock edge the machine moves from its current state to the state decoded from `mode_sel`, so any state can move to any other in one edge. Reset enters `MODE_FULL`. The rotation pointer names the thread that starts the fill. It steps by one every cycle so that no thread is always last in line.

Top module: `smt_issue_alloc`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the mode is unlimited and thread 0 starts the fill. With no ready work, all slots are invalid and the waste count equals the slot count.
- R2: Filled slots occupy the lowest slot indices with no gaps. Each thread's slots form one contiguous run. Runs follow rotation order, starting at the pointer thread and wrapping from the last thread to thread 0.
- R3: The per-thread limit follows the registered mode. `mode_sel` code 0 means unlimited, 1 means one, 2 means two, 3 means four, and 4 means fine mode. Codes 5 to 7 behave as code 0.
- R4: A thread's grant count equals the number of valid slots tagged with its number. It is the minimum of its ready count, its limit and the slots still free when its turn comes.
- R5: A thread whose stall flag is set, or whose ready count is zero, receives no slots and a grant of zero. It is skipped without consuming its turn's slots.
- R6: The waste count equals the slot count minus the number of valid slots, in every cycle.
- R7: The rotation pointer advances by one thread per cycle after reset and wraps from the last thread to thread 0.
- R8: A new `mode_sel` value has no effect in the cycle in which it is first driven. It governs the allocation from the cycle after the next clock edge.
- R9: In fine mode, at most one thread receives slots in a cycle. That thread is the first eligible one in rotation order, and it may take every slot.
- R10: Under a limit of two, four eligible threads that each have at least two ready instructions fill all eight slots, leaving a waste count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Issue mode code, registered at each edge |
| thr_stall | input | NUM_THREADS | Per-thread stall flag |
| thr_ready | input | NUM_THREADS*CNT_W | Per-thread ready instruction count, thread t in bits [t*CNT_W +: CNT_W] |
| slot_valid | output | NUM_SLOTS | Slot carries an instruction this cycle |
| slot_tid | output | NUM_SLOTS*TID_W | Owning thread of slot s in bits [s*TID_W +: TID_W] |
| thr_grant | output | NUM_THREADS*CNT_W | Slots granted to each thread this cycle |
| waste_cnt | output | CNT_W | Number of unfilled slots this cycle |

## Verification
The checker checks these properties on every cycle: valid slots are packed low, the waste count and the total of the grants agree with the number of valid slots, no thread exceeds the limit of its mode, stalled or idle threads get nothing, fine mode grants to at most one thread, and the pointer steps by one. The exact run order, the slot contents under each limit, the one-cycle delay of a mode change and the case where four threads fill the machine under a limit of two depend on a full prediction. Only the bench's reference model, compared on every clock over directed and random scenarios, shows them.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

    typedef enum logic [2:0] {
        MODE_FULL = 3'd0,
        MODE_CAP1 = 3'd1,
        MODE_CAP2 = 3'd2,
        MODE_CAP4 = 3'd3,
        MODE_FINE = 3'd4
    } mode_e;

    function automatic mode_e decode_mode(input logic [2:0] code);
        mode_e m;
        unique case (code)
            3'd1:    m = MODE_CAP1;
            3'd2:    m = MODE_CAP2;
            3'd3:    m = MODE_CAP4;
            3'd4:    m = MODE_FINE;
            default: m = MODE_FULL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/smt_mode_fsm.sv
module smt_mode_fsm
    import smt_issue_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    output mode_e            mode_q,
    output logic [CNT_W-1:0] cap_lim,
    output logic             one_thread
);

    mode_e mode_d;

    always_comb begin
        mode_d = decode_mode(mode_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FULL;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        one_thread = 1'b0;
        unique case (mode_q)
            MODE_CAP1: cap_lim = CNT_W'(1);
            MODE_CAP2: cap_lim = CNT_W'(2);
            MODE_CAP4: cap_lim = CNT_W'(4);
            MODE_FINE: begin
                cap_lim    = CNT_W'(NUM_SLOTS);
                one_thread = 1'b1;
            end
            default:   cap_lim = CNT_W'(NUM_SLOTS);
        endcase
    end

endmodule

// File: rtl/smt_rot_ptr.sv
module smt_rot_ptr #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] ptr_q
);

    localparam logic [TID_W-1:0] LAST = TID_W'(NUM_THREADS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_q == LAST) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + TID_W'(1);
        end
    end

endmodule

// File: rtl/smt_slot_fill.sv
module smt_slot_fill #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int TID_W       = 3,
    parameter int CNT_W       = 4
) (
    input  logic [TID_W-1:0]             start_ptr,
    input  logic [CNT_W-1:0]             cap_lim,
    input  logic                         one_thread,
    input  logic [NUM_THREADS-1:0]       stall,
    input  logic [NUM_THREADS*CNT_W-1:0] ready,
    output logic [NUM_SLOTS-1:0]         valid,
    output logic [NUM_SLOTS*TID_W-1:0]   tid,
    output logic [NUM_THREADS*CNT_W-1:0] grant,
    output logic [CNT_W-1:0]             waste
);

    always_comb begin
        int   left;
        int   base;
        int   take;
        int   t;
        int   rdy;
        logic served;
        valid  = '0;
        tid    = '0;
        grant  = '0;
        left   = NUM_SLOTS;
        base   = 0;
        served = 1'b0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            t = int'(start_ptr) + k;
            if (t >= NUM_THREADS) t = t - NUM_THREADS;
            rdy  = int'(ready[t*CNT_W +: CNT_W]);
            take = 0;
            if (!stall[t] && (rdy != 0) && !(one_thread && served)) begin
                take = rdy;
                if (take > int'(cap_lim)) take = int'(cap_lim);
                if (take > left) take = left;
                if (take > 0) served = 1'b1;
            end
            grant[t*CNT_W +: CNT_W] = CNT_W'(take);
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if ((s >= base) && (s < base + take)) begin
                    valid[s]                = 1'b1;
                    tid[s*TID_W +: TID_W]   = TID_W'(t);
                end
            end
            base = base + take;
            left = left - take;
        end
        waste = CNT_W'(left);
    end

endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc
    import smt_issue_pkg::*;
#(
    parameter  int NUM_THREADS = 8,
    parameter  int NUM_SLOTS   = 8,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W       = $clog2(NUM_SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   mode_sel,
    input  logic [NUM_THREADS-1:0]       thr_stall,
    input  logic [NUM_THREADS*CNT_W-1:0] thr_ready,
    output logic [NUM_SLOTS-1:0]         slot_valid,
    output logic [NUM_SLOTS*TID_W-1:0]   slot_tid,
    output logic [NUM_THREADS*CNT_W-1:0] thr_grant,
    output logic [CNT_W-1:0]             waste_cnt
);

    mode_e            mode_q;
    logic [CNT_W-1:0] cap_lim;
    logic             one_thread;
    logic [TID_W-1:0] start_ptr;

    smt_mode_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .mode_q     (mode_q),
        .cap_lim    (cap_lim),
        .one_thread (one_thread)
    );

    smt_rot_ptr #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr_q (start_ptr)
    );

    smt_slot_fill #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_SLOTS   (NUM_SLOTS),
        .TID_W       (TID_W),
        .CNT_W       (CNT_W)
    ) fill_i (
        .start_ptr  (start_ptr),
        .cap_lim    (cap_lim),
        .one_thread (one_thread),
        .stall      (thr_stall),
        .ready      (thr_ready),
        .valid      (slot_valid),
        .tid        (slot_tid),
        .grant      (thr_grant),
        .waste      (waste_cnt)
    );

endmodule

// File: rtl/smt_issue_alloc_chk.sv
module smt_issue_alloc_chk #(
    parameter  int NUM_THREADS = 8,
    parameter  int NUM_SLOTS   = 8,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W       = $clog2(NUM_SLOTS + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [2:0]                   mode_q,
    input logic [TID_W-1:0]             ptr,
    input logic [NUM_THREADS-1:0]       thr_stall,
    input logic [NUM_THREADS*CNT_W-1:0] thr_ready,
    input logic [NUM_SLOTS-1:0]         slot_valid,
    input logic [NUM_THREADS*CNT_W-1:0] thr_grant,
    input logic [CNT_W-1:0]             waste_cnt
);

    int                     grant_sum;
    int                     cap_now;
    logic [NUM_THREADS-1:0] got_any;
    logic [TID_W-1:0]       ptr_prev;
    logic                   ptr_seen;

    always_comb begin
        grant_sum = 0;
        got_any   = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            grant_sum  = grant_sum + int'(thr_grant[t*CNT_W +: CNT_W]);
            got_any[t] = (thr_grant[t*CNT_W +: CNT_W] != '0);
        end
        case (mode_q)
            3'd1:    cap_now = 1;
            3'd2:    cap_now = 2;
            3'd3:    cap_now = 4;
            default: cap_now = NUM_SLOTS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_prev <= '0;
            ptr_seen <= 1'b0;
        end else begin
            ptr_prev <= ptr;
            ptr_seen <= 1'b1;
        end
    end

    assert_packed_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid & (slot_valid + NUM_SLOTS'(1))) == '0);

    assert_waste_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(waste_cnt) + $countones(slot_valid) == NUM_SLOTS);

    assert_grant_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_sum == $countones(slot_valid));

    assert_fine_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd4) |-> $onehot0(got_any));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_seen |-> (ptr == ((ptr_prev == TID_W'(NUM_THREADS - 1)) ? '0 : ptr_prev + TID_W'(1))));

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
        assert_idle_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_stall[g] || (thr_ready[g*CNT_W +: CNT_W] == '0)) |-> !got_any[g]);

        assert_cap_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(thr_grant[g*CNT_W +: CNT_W]) <= cap_now);
    end

endmodule

bind smt_issue_alloc smt_issue_alloc_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_SLOTS   (NUM_SLOTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .ptr        (start_ptr),
    .thr_stall  (thr_stall),
    .thr_ready  (thr_ready),
    .slot_valid (slot_valid),
    .thr_grant  (thr_grant),
    .waste_cnt  (waste_cnt)
);

// File: tb/smt_issue_alloc_tb_top.sv
`timescale 1ns/1ps
module smt_issue_alloc_tb_top;

    localparam int NT = 8;
    localparam int NS = 8;
    localparam int TW = 3;
    localparam int CW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_sel = 3'd0;
    logic [NT-1:0]    stall = '0;
    logic [NT*CW-1:0] ready = '0;
    logic [NS-1:0]    slot_valid;
    logic [NS*TW-1:0] slot_tid;
    logic [NT*CW-1:0] grant;
    logic [CW-1:0]    waste;

    always #10 clk = ~clk;

    smt_issue_alloc #(.NUM_THREADS(NT), .NUM_SLOTS(NS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .thr_stall  (stall),
        .thr_ready  (ready),
        .slot_valid (slot_valid),
        .slot_tid   (slot_tid),
        .thr_grant  (grant),
        .waste_cnt  (waste)
    );

    int n_chk = 0;
    int n_bad = 0;
    int m_ptr = 0;
    int m_mode = 0;
    bit finished = 0;
    int e_tid[NS];
    int e_grant[NT];
    int e_used;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int limit_of(input int md);
        case (md)
            1: return 1;
            2: return 2;
            3: return 4;
            default: return NS;
        endcase
    endfunction

    function automatic int to_mode(input int code);
        return (code <= 4) ? code : 0;
    endfunction

    task automatic predict();
        int q[$];
        int lim;
        int t;
        int r;
        int n;
        lim = limit_of(m_mode);
        for (int i = 0; i < NT; i++) e_grant[i] = 0;
        for (int k = 0; k < NT; k++) begin
            t = (m_ptr + k) % NT;
            r = int'(ready[t*CW +: CW]);
            if (stall[t] || r == 0) continue;
            if (m_mode == 4 && q.size() > 0) break;
            n = r;
            if (n > lim) n = lim;
            if (n > NS - q.size()) n = NS - q.size();
            e_grant[t] = n;
            repeat (n) q.push_back(t);
        end
        e_used = q.size();
        for (int s = 0; s < NS; s++) e_tid[s] = (s < e_used) ? q[s] : -1;
    endtask

    function automatic int slot_code(input int s);
        return slot_valid[s] ? int'(slot_tid[s*TW +: TW]) : -1;
    endfunction

    task automatic compare_all(input string tag);
        predict();
        for (int s = 0; s < NS; s++)
            check(slot_code(s) == e_tid[s], "R2", {tag, " slot owner"}, slot_code(s), e_tid[s]);
        for (int t = 0; t < NT; t++)
            check(int'(grant[t*CW +: CW]) == e_grant[t], "R4", {tag, " grant"},
                  int'(grant[t*CW +: CW]), e_grant[t]);
        check(int'(waste) == NS - e_used, "R6", {tag, " waste"}, int'(waste), NS - e_used);
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic advance();
        m_ptr  = (m_ptr + 1) % NT;
        m_mode = to_mode(int'(mode_sel));
        @(negedge clk);
    endtask

    task automatic tick(input string tag);
        settle();
        compare_all(tag);
        advance();
    endtask

    task automatic set_all(input int v);
        for (int t = 0; t < NT; t++) ready[t*CW +: CW] = CW'(v);
    endtask

    function automatic int distinct_owners();
        bit seen[NT];
        int c;
        c = 0;
        for (int t = 0; t < NT; t++) seen[t] = 0;
        for (int s = 0; s < NS; s++)
            if (slot_valid[s] && !seen[slot_tid[s*TW +: TW]]) begin
                seen[slot_tid[s*TW +: TW]] = 1;
                c++;
            end
        return c;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        settle();
        // R1: reset state with nothing ready
        check(slot_valid == '0, "R1", "valid in reset", int'(slot_valid), 0);
        check(int'(waste) == NS, "R1", "waste in reset", int'(waste), NS);
        @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0;
        m_mode = 0;

        // R1 / R7: unlimited mode, everyone has 8 ready; slot 0 names the pointer thread
        set_all(8);
        for (int c = 0; c < 10; c++) begin
            settle();
            check(slot_code(0) == m_ptr, (c == 0) ? "R1" : "R7", "pointer owner",
                  slot_code(0), m_ptr);
            compare_all("full");
            advance();
        end

        // R8: new code has no effect this cycle
        mode_sel = 3'd1;
        settle();
        check(int'(grant[m_ptr*CW +: CW]) == NS, "R8", "old mode kept", int'(grant[m_ptr*CW +: CW]), NS);
        compare_all("switch");
        advance();
        // R3: limit of one, every thread one slot
        for (int c = 0; c < 3; c++) begin
            settle();
            check(int'(grant[c*CW +: CW]) == 1, "R3", "cap1 grant", int'(grant[c*CW +: CW]), 1);
            compare_all("cap1");
            advance();
        end

        // R10: limit two, four threads with 3 ready fill the machine
        mode_sel = 3'd2;
        tick("to cap2");
        set_all(0);
        for (int t = 0; t < 4; t++) ready[t*CW +: CW] = CW'(3);
        for (int c = 0; c < 4; c++) begin
            settle();
            check(int'(waste) == 0, "R10", "cap2 waste", int'(waste), 0);
            compare_all("cap2");
            advance();
        end
        // only three threads: waste of two under limit two
        ready[3*CW +: CW] = '0;
        tick("cap2 short");

        // R5: stalled threads with work are skipped, limit four
        mode_sel = 3'd3;
        set_all(5);
        stall = 8'b1010_0101;
        tick("to cap4");
        for (int c = 0; c < 4; c++) begin
            settle();
            check(int'(grant[0*CW +: CW]) == 0, "R5", "stalled grant", int'(grant[0*CW +: CW]), 0);
            compare_all("cap4 stall");
            advance();
        end
        stall = '0;
        ready[1*CW +: CW] = '0;
        tick("cap4 zero ready");

        // R9: fine mode, one thread per cycle
        mode_sel = 3'd4;
        set_all(3);
        tick("to fine");
        for (int c = 0; c < 6; c++) begin
            settle();
            check(distinct_owners() == 1, "R9", "fine owners", distinct_owners(), 1);
            compare_all("fine");
            advance();
        end

        // R3: unused codes behave as unlimited
        mode_sel = 3'd6;
        set_all(8);
        tick("to code6");
        settle();
        check(int'(grant[m_ptr*CW +: CW]) == NS, "R3", "code6 unlimited", int'(grant[m_ptr*CW +: CW]), NS);
        compare_all("code6");
        advance();

        // random traffic across all modes
        for (int c = 0; c < 400; c++) begin
            for (int t = 0; t < NT; t++) ready[t*CW +: CW] = CW'($urandom_range(0, 9));
            stall = NT'($urandom & $urandom);
            if (c % 5 == 0) mode_sel = 3'($urandom_range(0, 7));
            tick("random");
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule